// File: doc/BRIEF.md
# Cascadable Start-Pulse Capture Sequencer

This block sequences display-data sampling for one segment of a daisy-chained column driver. A start pulse arrives on one of two bidirectional pins. The block then enables one capture slot per clock, across a parameterised number of slots, and walks them either upward or downward. Near the end of the sweep it hands a one-clock start pulse to the next segment, so that segment continues the capture on the following clock without a gap. Two clocks after the cascade pulse, the sweep stops by itself and the block waits for the next start.

The direction input decides which pin listens and which pin talks. When the direction input is high, the right pin receives the start pulse, the slots run from index 0 upward, and the left pin carries the cascade pulse. When the direction input is low, all of these are mirrored. The pin that listens is released to high impedance.

The rising edge of the line strobe aborts any sweep in progress. For the next two clock edges after that rise, the block refuses a new start pulse. A synchronous reset returns the block to idle.

Top module: `start_pulse_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `slot_en` is all zero and the cascade pin is low. A start pulse seen during reset launches no sweep.
- R2: When `dir_right`=1, the start input is `pin_r` and the cascade pulse appears on `pin_l`. When `dir_right`=0, the start input is `pin_l` and the cascade pulse appears on `pin_r`. The pin acting as input is not driven by the block.
- R3: Call the clock edge at which the start pin is sampled high, while the block is idle, edge 0. In the cycle after edge 0, exactly the first slot of the selected order is enabled.
- R4: In the cycle after edge n, for n from 0 to STAGES-1, exactly one bit of `slot_en` is set. That bit is n when `dir_right`=1 and STAGES-1-n when `dir_right`=0.
- R5: The cascade pin is high only in the cycle after edge STAGES-1, so the pulse is exactly one clock wide. It is driven low at all other times.
- R6: From the cycle after edge STAGES onward, no slot is enabled. The sweep stays busy through edge STAGES+1, so start pulses sampled on edges 1 to STAGES+1 are ignored. A start pulse sampled on edge STAGES+2 or later begins a new sweep.
- R7: On the clock edge that first samples `strobe` high after a low sample, the sweep is aborted. In the next cycle no slot is enabled and the cascade pin is low. A strobe that stays high causes no further action.
- R8: A start pulse sampled on that strobe-rise edge, or on the edge after it, is ignored. A start pulse sampled on the second edge after the rise is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dir_right | input | 1 | 1: start on pin_r, ascending slots; 0: start on pin_l, descending slots |
| strobe | input | 1 | Line strobe; its rising edge aborts the sweep |
| pin_r | inout | 1 | Start input (dir_right=1) or cascade output (dir_right=0) |
| pin_l | inout | 1 | Cascade output (dir_right=1) or start input (dir_right=0) |
| slot_en | output | STAGES | One-hot capture-slot enable |

## Verification
The bench builds the block with STAGES=6. With that size, every sweep position can be visited in both directions, and the mapping of each slot is checked against an arithmetic index. A repeated start is injected at every edge from 1 to STAGES+2, which covers every busy edge and the first accepting edge. A strobe rise is applied at every position of the sweep, and a start is placed at each of the three hold-off offsets.

// File: rtl/start_pulse_sequencer.sv
module start_pulse_sequencer #(
  parameter int STAGES = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_right,
  input  logic              strobe,
  inout  wire               pin_r,
  inout  wire               pin_l,
  output logic [STAGES-1:0] slot_en
);
  localparam int PW = $clog2(STAGES + 1);
  localparam logic [PW-1:0] LAST = PW'(STAGES - 1);
  localparam logic [PW-1:0] STOP = PW'(STAGES);

  logic          running, stb_q, hold;
  logic [PW-1:0] pos;

  wire start_in = dir_right ? pin_r : pin_l;
  wire stb_rise = strobe & ~stb_q;
  wire casc     = running && (pos == LAST);

  assign pin_l = dir_right ? casc : 1'bz;
  assign pin_r = dir_right ? 1'bz : casc;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pos     <= '0;
      stb_q   <= 1'b0;
      hold    <= 1'b0;
    end else begin
      stb_q <= strobe;
      hold  <= stb_rise;
      if (stb_rise) begin
        running <= 1'b0;
        pos     <= '0;
      end else if (running) begin
        if (pos == STOP) running <= 1'b0;
        else             pos     <= pos + PW'(1);
      end else if (start_in && !hold) begin
        running <= 1'b1;
        pos     <= '0;
      end
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_slot
    assign slot_en[k] = running &&
      (pos == (dir_right ? PW'(k) : PW'(STAGES - 1 - k)));
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (slot_en == '0 && !casc));

  p_onehot_slots_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_en));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    casc |=> !casc);

  p_halt_r6: assert property (@(posedge clk) disable iff (rst)
    casc |-> ##2 (slot_en == '0));

  p_strobe_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe && !stb_q) |=> (slot_en == '0 && !casc));
endmodule

// File: tb/tb_start_pulse_sequencer.sv
module tb_start_pulse_sequencer;
  localparam int N = 6;
  localparam time CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, dir = 1'b1, strobe = 1'b0, drv = 1'b0;
  logic done = 1'b0;
  wire pin_r, pin_l;
  logic [N-1:0] slot_en;
  int errs = 0, checks = 0;

  assign pin_r = dir ? drv : 1'bz;
  assign pin_l = dir ? 1'bz : drv;
  wire casc_obs = dir ? pin_l : pin_r;

  start_pulse_sequencer #(.STAGES(N)) dut (
    .clk(clk), .rst(rst), .dir_right(dir), .strobe(strobe),
    .pin_r(pin_r), .pin_l(pin_l), .slot_en(slot_en));

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_slot(input logic d, input int n);
    if (n < 0 || n >= N) return 0;
    return 1 << (d ? n : N - 1 - n);
  endfunction

  // R2 R3 R4 R5 R6: start at edge 0, optional repeat start at edge 'again'
  task automatic sweep(input logic d, input int again);
    dir = d; drv = 1'b1;
    tick();
    for (int n = 0; n <= N + 1; n++) begin
      chk(n == 0 ? "R3" : "R4", int'(slot_en), exp_slot(d, n));
      chk(d ? "R5 R2 pin_l" : "R5 R2 pin_r", int'(casc_obs), int'(n == N - 1));
      drv = (n + 1 == again);
    end_loop_tick: tick();
    end
    chk("R6", int'(slot_en), again == N + 2 ? exp_slot(d, 0) : 0);
    drv = 1'b0;
    for (int i = 0; i < N + 3; i++) tick();
    chk("R6 idle", int'(slot_en), 0);
  endtask

  // R7: strobe rise after edge k of a sweep
  task automatic strobe_abort(input logic d, input int k);
    dir = d; drv = 1'b1;
    tick();
    drv = 1'b0;
    for (int i = 0; i < k; i++) tick();
    strobe = 1'b1;
    tick();
    chk("R7 slots", int'(slot_en), 0);
    chk("R7 casc", int'(casc_obs), 0);
    tick();
    chk("R7 held", int'(slot_en), 0);
    strobe = 1'b0;
    tick();
  endtask

  // R8: start placed at offset off from the strobe-rise edge
  task automatic holdoff(input logic d, input int off);
    dir = d;
    strobe = 1'b1; drv = (off == 0);
    tick();
    chk("R8 off0", int'(slot_en), 0);
    drv = (off == 1);
    tick();
    chk("R8 off1", int'(slot_en), 0);
    drv = (off == 2);
    tick();
    chk("R8 off2", int'(slot_en), off == 2 ? exp_slot(d, 0) : 0);
    drv = 1'b0; strobe = 1'b0;
    for (int i = 0; i < N + 3; i++) tick();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; drv = 1'b1;
    @(negedge clk);
    tick(); tick();
    chk("R1 slots", int'(slot_en), 0);
    chk("R1 casc", int'(casc_obs), 0);
    drv = 1'b0; rst = 1'b0;
    tick();
    chk("R1 after", int'(slot_en), 0);

    sweep(1'b1, 0);
    sweep(1'b0, 0);
    for (int r = 1; r <= N + 2; r++) begin
      sweep(1'b1, r);
      sweep(1'b0, r);
    end
    for (int k = 0; k <= N + 1; k++) begin
      strobe_abort(1'b1, k);
      strobe_abort(1'b0, k);
    end
    for (int o = 0; o < 3; o++) begin
      holdoff(1'b1, o);
      holdoff(1'b0, o);
    end

    // R1: reset in mid-sweep
    dir = 1'b1; drv = 1'b1;
    tick();
    drv = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    chk("R1 mid", int'(slot_en), 0);
    rst = 1'b0;
    tick();
    chk("R1 mid after", int'(slot_en), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule